// File: doc/BRIEF.md
# Downstream Port Power and Status Light Controller

This block manages the supply switches, fault sensing and two-colour status lights for the downstream ports of a hub. Each port has a request that asks for its power to be switched on. The block gates that request with the active-port mask and with the fault state, and drives an enable pin per port whose active level is set by configuration. Fault inputs are active low. A fault must stay present for a set number of cycles before it counts. An accepted fault cuts the port's power, raises a status bit and sets a sticky change bit. Firmware clears the change bit with a one-cycle pulse.

In ganged mode the ports share one switch and one fault sense. Only the first port's fault input is watched, and a fault there is reported on every active port. Only the first enable pin is driven. The status lights run either automatically from power and fault state, or from a 2-bit code per port chosen by firmware. All lights go dark during global suspend. The amber lines are held off while a configuration memory shares those pins.

Top module: `dsp_power_ctrl`

## Requirements
- R1: While `rst` is high, every enable pin sits at its inactive level, and all status, change and light outputs are 0.
- R2: A fault on a monitored input is accepted only after `oc_n` has been low for DEB_CYC consecutive clock edges. `oc_status` rises one edge after acceptance. A shorter low pulse has no effect on any output.
- R3: An accepted fault removes power from the affected port(s). A port whose power was cut stays unpowered, even after the fault goes away, until its request is dropped and raised again.
- R4: `oc_change[i]` sets when `oc_status[i]` rises and stays set until an `oc_clr[i]` pulse. If the set and the clear fall on the same edge, the set wins.
- R5: In ganged mode only `oc_n[0]` is monitored. An accepted fault on it is reported on every active port, and the other fault inputs are ignored.
- R6: In ganged mode only `pwr_en[0]` is driven. It is active when any active port requests power and is not cut off. The other pins stay inactive.
- R7: With `cfg_en_high`=1 the enable pins are active high. With 0 they are active low.
- R8: A port outside `cfg_port_mask` has its enable inactive, its lights off, and no fault status.
- R9: In automatic mode a port shows amber on a fault, green when it is powered with no fault, and dark otherwise. Green and amber are never lit together.
- R10: With `led_manual`=1, port i's code `led_code[2i+1:2i]` selects the light: 00 off, 01 green, 10 amber, 11 automatic.
- R11: While `suspend` is high, all lights are off (one edge later).
- R12: While `cfg_eeprom` is high, all amber outputs are 0 (one edge later).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req | input | NPORT | Per-port power-on request |
| oc_n | input | NPORT | Active-low fault (over-current) sense per port |
| oc_clr | input | NPORT | One-cycle pulse that clears the matching change bit |
| cfg_gang | input | 1 | 1 = ganged power mode |
| cfg_en_high | input | 1 | 1 = enable pins active high, 0 = active low |
| cfg_port_mask | input | NPORT | 1 = port is present and active |
| cfg_eeprom | input | 1 | 1 = amber pins shared with a configuration memory |
| suspend | input | 1 | Global suspend |
| led_manual | input | 1 | 1 = lights follow `led_code` |
| led_code | input | 2*NPORT | 2-bit light code per port |
| pwr_en | output | NPORT | Power switch enable pins |
| oc_status | output | NPORT | Accepted fault per port |
| oc_change | output | NPORT | Sticky fault-change bit per port |
| led_green | output | NPORT | Green light drive |
| led_amber | output | NPORT | Amber light drive |

## Verification
Two situations are the hardest to reach from the ports. The first is a clear pulse that lands on the same edge as a new fault acceptance. To get there, the bench holds `oc_clr` high across the whole debounce window. The acceptance edge then always coincides with the clear, whatever the filter length. The second is re-arming after a ganged trip: the fault is removed, then a single port's request is cycled, and the shared pin must come back because of that one port alone. Debounce boundaries are hit by counting edges from the point `oc_n` falls, with pulses one cycle short of the filter length and pulses exactly as long as it.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  typedef enum logic [1:0] {
    LED_OFF  = 2'b00,
    LED_GRN  = 2'b01,
    LED_AMB  = 2'b10,
    LED_AUTO = 2'b11
  } led_code_e;
endpackage

// File: rtl/dsp_oc_filter.sv
module dsp_oc_filter #(
  parameter int DEB_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fault_in,
  output logic fault_ok
);
  localparam int CW = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      fault_ok <= 1'b0;
    end else if (!fault_in) begin
      cnt      <= '0;
      fault_ok <= 1'b0;
    end else if (cnt == LAST) begin
      fault_ok <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dsp_led_sel.sv
module dsp_led_sel
  import dsp_pkg::*;
(
  input  logic [1:0] code,
  input  logic       manual,
  input  logic       fault,
  input  logic       powered,
  input  logic       dark,
  input  logic       amber_block,
  output logic       green,
  output logic       amber
);
  logic auto_g, auto_a;

  always_comb begin
    auto_a = fault;
    auto_g = powered & ~fault;
    if (!manual) begin
      green = auto_g;
      amber = auto_a;
    end else begin
      case (led_code_e'(code))
        LED_OFF: begin green = 1'b0; amber = 1'b0; end
        LED_GRN: begin green = 1'b1; amber = 1'b0; end
        LED_AMB: begin green = 1'b0; amber = 1'b1; end
        default: begin green = auto_g; amber = auto_a; end
      endcase
    end
    if (dark) begin
      green = 1'b0;
      amber = 1'b0;
    end
    if (amber_block) amber = 1'b0;
  end
endmodule

// File: rtl/dsp_power_ctrl.sv
module dsp_power_ctrl
  import dsp_pkg::*;
#(
  parameter int NPORT   = 4,
  parameter int DEB_CYC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPORT-1:0]   pwr_req,
  input  logic [NPORT-1:0]   oc_n,
  input  logic [NPORT-1:0]   oc_clr,
  input  logic               cfg_gang,
  input  logic               cfg_en_high,
  input  logic [NPORT-1:0]   cfg_port_mask,
  input  logic               cfg_eeprom,
  input  logic               suspend,
  input  logic               led_manual,
  input  logic [2*NPORT-1:0] led_code,
  output logic [NPORT-1:0]   pwr_en,
  output logic [NPORT-1:0]   oc_status,
  output logic [NPORT-1:0]   oc_change,
  output logic [NPORT-1:0]   led_green,
  output logic [NPORT-1:0]   led_amber
);
  logic [NPORT-1:0] flt, eff, on, port_pwr, drive;
  logic [NPORT-1:0] trip_q, status_q, change_q, pins_q;
  logic [NPORT-1:0] grn_d, amb_d, grn_q, amb_q;
  logic             shared;

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    dsp_oc_filter #(.DEB_CYC(DEB_CYC)) u_flt (
      .clk      (clk),
      .rst      (rst),
      .fault_in (~oc_n[i]),
      .fault_ok (flt[i])
    );
    dsp_led_sel u_led (
      .code        (led_code[2*i +: 2]),
      .manual      (led_manual),
      .fault       (eff[i]),
      .powered     (port_pwr[i]),
      .dark        (suspend | ~cfg_port_mask[i]),
      .amber_block (cfg_eeprom),
      .green       (grn_d[i]),
      .amber       (amb_d[i])
    );
  end

  // Fault, power and pin drive for this cycle
  always_comb begin
    eff      = (cfg_gang ? {NPORT{flt[0]}} : flt) & cfg_port_mask;
    on       = pwr_req & cfg_port_mask & ~trip_q & ~eff;
    shared   = |on;
    port_pwr = cfg_gang ? ({NPORT{shared}} & cfg_port_mask) : on;
    drive    = cfg_gang ? {{(NPORT-1){1'b0}}, shared} : on;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q   <= {NPORT{~cfg_en_high}};
      trip_q   <= '0;
      status_q <= '0;
      change_q <= '0;
      grn_q    <= '0;
      amb_q    <= '0;
    end else begin
      pins_q   <= drive ^ {NPORT{~cfg_en_high}};
      trip_q   <= pwr_req & (trip_q | eff);
      status_q <= eff;
      change_q <= (change_q & ~oc_clr) | (eff & ~status_q);
      grn_q    <= grn_d;
      amb_q    <= amb_d;
    end
  end

  assign pwr_en    = pins_q;
  assign oc_status = status_q;
  assign oc_change = change_q;
  assign led_green = grn_q;
  assign led_amber = amb_q;
endmodule

// File: rtl/dsp_power_ctrl_chk.sv
module dsp_power_ctrl_chk #(
  parameter int NPORT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NPORT-1:0] oc_clr,
  input logic             cfg_gang,
  input logic             cfg_en_high,
  input logic [NPORT-1:0] cfg_port_mask,
  input logic             cfg_eeprom,
  input logic             suspend,
  input logic [NPORT-1:0] pwr_en,
  input logic [NPORT-1:0] oc_status,
  input logic [NPORT-1:0] oc_change,
  input logic [NPORT-1:0] led_green,
  input logic [NPORT-1:0] led_amber
);
  a_r11_dark_in_suspend: assert property (@(posedge clk) disable iff (rst)
    suspend |=> (led_green == '0 && led_amber == '0));

  a_r12_amber_quiet: assert property (@(posedge clk) disable iff (rst)
    cfg_eeprom |=> (led_amber == '0));

  a_r8_masked_dark: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((led_green | led_amber | oc_status) & ~$past(cfg_port_mask)) == '0));

  a_r6_gang_idle_pins: assert property (@(posedge clk) disable iff (rst)
    cfg_gang |=> (pwr_en[NPORT-1:1] == {(NPORT-1){~$past(cfg_en_high)}}));

  a_r4_sticky_change: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(oc_change) & ~$past(oc_clr) & ~oc_change) == '0));

  a_r9_one_colour: assert property (@(posedge clk) disable iff (rst)
    (led_green & led_amber) == '0);

  a_r3_fault_cuts_power: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($past(cfg_gang)
              ? !((|oc_status) && (pwr_en[0] == $past(cfg_en_high)))
              : ((oc_status & (pwr_en ^ {NPORT{~$past(cfg_en_high)}})) == '0)));
endmodule

bind dsp_power_ctrl dsp_power_ctrl_chk #(.NPORT(NPORT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .oc_clr        (oc_clr),
  .cfg_gang      (cfg_gang),
  .cfg_en_high   (cfg_en_high),
  .cfg_port_mask (cfg_port_mask),
  .cfg_eeprom    (cfg_eeprom),
  .suspend       (suspend),
  .pwr_en        (pwr_en),
  .oc_status     (oc_status),
  .oc_change     (oc_change),
  .led_green     (led_green),
  .led_amber     (led_amber)
);

// File: tb/dsp_power_ctrl_tb.sv
`timescale 1ns/1ps
module dsp_power_ctrl_tb;
  localparam int N   = 4;
  localparam int DEB = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] pwr_req, oc_n, oc_clr, cfg_port_mask;
  logic         cfg_gang, cfg_en_high, cfg_eeprom, suspend, led_manual;
  logic [2*N-1:0] led_code;
  logic [N-1:0] pwr_en, oc_status, oc_change, led_green, led_amber;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dsp_power_ctrl #(.NPORT(N), .DEB_CYC(DEB)) u_dut (
    .clk(clk), .rst(rst), .pwr_req(pwr_req), .oc_n(oc_n), .oc_clr(oc_clr),
    .cfg_gang(cfg_gang), .cfg_en_high(cfg_en_high), .cfg_port_mask(cfg_port_mask),
    .cfg_eeprom(cfg_eeprom), .suspend(suspend), .led_manual(led_manual),
    .led_code(led_code), .pwr_en(pwr_en), .oc_status(oc_status),
    .oc_change(oc_change), .led_green(led_green), .led_amber(led_amber)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; pwr_req = '0; oc_n = '1; oc_clr = '0; cfg_port_mask = '1;
    cfg_gang = 0; cfg_en_high = 0; cfg_eeprom = 0; suspend = 0;
    led_manual = 0; led_code = '0;
    tick(3);
    // R1 reset state, low-active pins idle high
    chk("R1 pins", pwr_en, 4'hF);
    chk("R1 status", {oc_status, oc_change}, 8'h00);
    chk("R1 leds", {led_green, led_amber}, 8'h00);
    rst = 0;

    // R7 polarity, R9 green when powered
    pwr_req = '1;
    tick();
    chk("R7 low-active on", pwr_en, 4'h0);
    chk("R9 auto green", led_green, 4'hF);
    cfg_en_high = 1;
    tick();
    chk("R7 high-active on", pwr_en, 4'hF);

    // R8 mask sweep
    for (int m = 0; m < 16; m++) begin
      cfg_port_mask = 4'(m);
      tick();
      chk("R8 pins vs mask", pwr_en, 32'(m));
      chk("R8 lights vs mask", {led_green, led_amber}, {4'(m), 4'h0});
    end
    cfg_port_mask = '1;
    tick();

    // R2 short pulse ignored
    oc_n[2] = 0;
    tick(DEB - 1);
    oc_n[2] = 1;
    tick(2);
    chk("R2 short pulse status", oc_status, 4'h0);
    chk("R2 short pulse pins", pwr_en, 4'hF);

    // R2 full-length fault accepted exactly on time
    oc_n[2] = 0;
    tick(DEB);
    chk("R2 not yet accepted", oc_status, 4'h0);
    tick();
    chk("R2 accepted", oc_status, 4'h4);
    chk("R3 power cut", pwr_en, 4'hB);
    chk("R9 amber on fault", {led_green, led_amber}, {4'hB, 4'h4});
    chk("R4 change set", oc_change, 4'h4);
    oc_n[2] = 1;
    tick(2);
    chk("R2 status cleared", oc_status, 4'h0);
    chk("R3 stays cut", pwr_en, 4'hB);
    pwr_req[2] = 0; tick();
    pwr_req[2] = 1; tick(2);
    chk("R3 re-request restores", pwr_en, 4'hF);
    chk("R4 still sticky", oc_change, 4'h4);
    oc_clr[2] = 1; tick(); oc_clr[2] = 0;
    chk("R4 cleared by pulse", oc_change, 4'h0);

    // R4 set wins over simultaneous clear
    oc_clr[1] = 1; oc_n[1] = 0;
    tick(DEB + 1);
    chk("R4 set wins", oc_change, 4'h2);
    oc_clr[1] = 0; tick();
    chk("R4 held", oc_change, 4'h2);
    oc_clr[1] = 1; tick(); oc_clr[1] = 0; tick();
    chk("R4 clear during fault", oc_change, 4'h0);
    oc_n[1] = 1; tick(2);
    pwr_req[1] = 0; tick(); pwr_req[1] = 1; tick(2);
    chk("R3 port1 restored", pwr_en, 4'hF);

    // R6 gang: only pin 0
    cfg_gang = 1;
    tick();
    chk("R6 gang pins", pwr_en, 4'h1);
    chk("R6 gang green", led_green, 4'hF);
    // R5 other inputs ignored
    oc_n[3] = 0;
    tick(DEB + 2);
    chk("R5 port3 ignored status", oc_status, 4'h0);
    chk("R5 port3 ignored pins", pwr_en, 4'h1);
    oc_n[3] = 1;
    oc_n[0] = 0;
    tick(DEB + 1);
    chk("R5 gang fault all ports", oc_status, 4'hF);
    chk("R5 gang change all", oc_change, 4'hF);
    chk("R3 gang power cut", pwr_en, 4'h0);
    oc_n[0] = 1;
    tick(2);
    chk("R3 gang stays cut", pwr_en, 4'h0);
    pwr_req[2] = 0; tick(); pwr_req[2] = 1; tick(2);
    chk("R6 gang re-armed by one port", pwr_en, 4'h1);
    pwr_req = '0; oc_clr = '1; tick();
    oc_clr = '0;
    chk("R6 gang no request", pwr_en, 4'h0);
    cfg_en_high = 0; tick();
    chk("R7 gang low-active idle", pwr_en, 4'hF);
    pwr_req = '1; tick();
    chk("R7 gang low-active on", pwr_en, 4'hE);
    cfg_gang = 0; cfg_en_high = 1; tick();
    chk("R4 cleared after gang", oc_change, 4'h0);

    // R10 manual codes
    led_manual = 1;
    for (int c = 0; c < 4; c++) begin
      led_code = {4{2'(c)}};
      tick();
      chk("R10 green for code", led_green, (c == 1 || c == 3) ? 4'hF : 4'h0);
      chk("R10 amber for code", led_amber, (c == 2) ? 4'hF : 4'h0);
    end
    led_code = {2'b11, 2'b10, 2'b01, 2'b00};
    tick();
    chk("R10 mixed codes", {led_green, led_amber}, {4'hA, 4'h4});

    // R11 suspend
    suspend = 1; tick();
    chk("R11 suspend dark", {led_green, led_amber}, 8'h00);
    suspend = 0; tick();
    chk("R11 wake restores", {led_green, led_amber}, {4'hA, 4'h4});

    // R12 shared memory blocks amber
    cfg_eeprom = 1; tick();
    chk("R12 amber held off", {led_green, led_amber}, {4'hA, 4'h0});
    cfg_eeprom = 0;

    // R9 auto: unpowered port is dark
    led_manual = 0; pwr_req = 4'hE; tick();
    chk("R9 unpowered dark", {led_green, led_amber}, {4'hE, 4'h0});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule